// File: doc/BRIEF.md
# Package Power-State Sequencer

This block tracks the power state of a processor package from four active-low sideband pins driven by system logic: stop-clock, sleep, deep-sleep and snoop request. It walks a five-step ladder of Normal, Stop Grant, Stop Grant Snoop, Sleep and Deep Sleep. Each deeper rung is reachable only from its shallower neighbour. Snoops are honoured only while the package sits in Stop Grant. Each snoop completes through a one-cycle done strobe from the snoop logic.

Every sideband pin passes through a synchronizer chain before the state logic sees it. A break-event pulse that arrives while stop-clock is asserted pulls the active-low pending-break output low. That output asks system logic to bring the package back to Normal, and it stays low until stop-clock is released. The state is presented both encoded and one-hot, together with the core and bus clock enables that belong to each state.

Top module: `pkg_power_seq`

## Requirements
- R1: From Normal (code 0), asserting stop-clock moves to Stop Grant (code 1). Releasing stop-clock in Stop Grant returns to Normal. Normal is entered only from Stop Grant.
- R2: In Stop Grant, an asserted snoop request moves to Stop Grant Snoop (code 2), taking priority over an asserted sleep pin. Stop Grant Snoop returns to Stop Grant in the cycle after snoopDone is high, and in no other way.
- R3: In Stop Grant with stop-clock still asserted and no snoop, asserting sleep enters Sleep (code 3). Releasing sleep in Sleep returns to Stop Grant. A stop-clock release in Stop Grant outranks snoop and sleep.
- R4: In Sleep, asserting deep-sleep enters Deep Sleep (code 4). Releasing deep-sleep returns to Sleep.
- R5: A breakEvt pulse sampled while synchronized stop-clock is asserted drives pbeN low on the next edge. A breakEvt pulse while stop-clock is not asserted leaves pbeN high.
- R6: Deep Sleep is entered only from Sleep. The deep-sleep pin has no effect in Normal or Stop Grant, and the sleep pin has no effect in Normal.
- R7: Once low, pbeN stays low until synchronized stop-clock is seen released, then returns high. Further break pulses while it is low change nothing.
- R8: Snoop requests are ignored in Sleep and Deep Sleep. In Stop Grant Snoop, changes on stop-clock, sleep and deep-sleep are ignored until the snoop completes.
- R9: coreClkEn is high only in Normal and Stop Grant Snoop. busClkEn is low only in Deep Sleep.
- R10: stateCode carries the codes above. stateOneHot has exactly bit stateCode set.
- R11: After reset the state is Normal, pbeN is high and both clock enables are high.
- R12: A pin change set up before a rising edge reaches the state outputs at the third rising edge: two synchronizer stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| stpClkN | input | 1 | Stop-clock request, active low, asynchronous |
| slpN | input | 1 | Sleep request, active low, asynchronous |
| dpSlpN | input | 1 | Deep-sleep request, active low, asynchronous |
| snoopReqN | input | 1 | Snoop request, active low, asynchronous |
| breakEvt | input | 1 | Break-event pulse, clock domain |
| snoopDone | input | 1 | Snoop completion strobe, clock domain |
| pbeN | output | 1 | Pending break, active low |
| stateCode | output | 3 | Encoded package state |
| stateOneHot | output | 5 | One-hot package state |
| coreClkEn | output | 1 | Core clock enable |
| busClkEn | output | 1 | Bus clock enable |

## Verification
Two pairs of events can land on the same edge. Snoop and sleep can both be asserted in Stop Grant. A break pulse can also coincide with the edge at which the stop-clock release clears the pending break. The bench drives snoop and sleep on the same cycle and expects the snoop rung to win. It then releases stop-clock while break pulses keep arriving, and expects pbeN to rise exactly three edges after the release. A sweep over every start state and all sixteen pin combinations compares the settled state and the clock enables against a ladder computed in the bench.

// File: rtl/pkgpwr_pkg.sv
package pkgpwr_pkg;
  localparam int NUM_STATES = 5;
  localparam int STATE_W    = $clog2(NUM_STATES);
  localparam int NUM_PINS   = 4;

  typedef enum logic [STATE_W-1:0] {
    PS_NORMAL    = 3'd0,
    PS_STOPGRANT = 3'd1,
    PS_SNOOP     = 3'd2,
    PS_SLEEP     = 3'd3,
    PS_DEEP      = 3'd4
  } pkgState_e;

  // synchronized pin activity, active high
  typedef struct packed {
    logic stop;
    logic sleep;
    logic deep;
    logic snoop;
  } pinAct_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pbeSet;
    logic pbeClr;
    logic coreEnNext;
    logic busEnNext;
  } ctrlStrobe_t;
endpackage

// File: rtl/pkgpwr_datapath.sv
module pkgpwr_datapath
  import pkgpwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRawN,
  input  ctrlStrobe_t         strobe,
  output pinAct_t             pinAct,
  output logic                pbeN,
  output logic                coreClkEn,
  output logic                busClkEn
);
  logic [NUM_PINS-1:0] pinSyncN;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], pinRawN[p]};
    end
    assign pinSyncN[p] = chain[SYNC_STAGES-1];
  end

  assign pinAct = ~pinSyncN;

  logic pbePending;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pbePending <= 1'b0;
    else if (strobe.pbeClr) pbePending <= 1'b0;
    else if (strobe.pbeSet) pbePending <= 1'b1;
  end
  assign pbeN = ~pbePending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreClkEn <= 1'b1;
      busClkEn  <= 1'b1;
    end else begin
      coreClkEn <= strobe.coreEnNext;
      busClkEn  <= strobe.busEnNext;
    end
  end
endmodule

// File: rtl/pkgpwr_ctrl.sv
module pkgpwr_ctrl
  import pkgpwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pinAct_t     pinAct,
  input  logic        breakEvt,
  input  logic        snoopDone,
  output ctrlStrobe_t strobe,
  output pkgState_e   state
);
  pkgState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      PS_NORMAL:    if (pinAct.stop) nextState = PS_STOPGRANT;
      PS_STOPGRANT: begin
        if (!pinAct.stop)      nextState = PS_NORMAL;
        else if (pinAct.snoop) nextState = PS_SNOOP;
        else if (pinAct.sleep) nextState = PS_SLEEP;
      end
      PS_SNOOP:     if (snoopDone) nextState = PS_STOPGRANT;
      PS_SLEEP: begin
        if (!pinAct.sleep)     nextState = PS_STOPGRANT;
        else if (pinAct.deep)  nextState = PS_DEEP;
      end
      PS_DEEP:      if (!pinAct.deep) nextState = PS_SLEEP;
      default:      nextState = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_NORMAL;
    else       state <= nextState;
  end

  always_comb begin
    strobe.pbeSet     = breakEvt & pinAct.stop;
    strobe.pbeClr     = ~pinAct.stop;
    strobe.coreEnNext = (nextState == PS_NORMAL) || (nextState == PS_SNOOP);
    strobe.busEnNext  = (nextState != PS_DEEP);
  end
endmodule

// File: rtl/pkg_power_seq.sv
module pkg_power_seq
  import pkgpwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stpClkN,
  input  logic                  slpN,
  input  logic                  dpSlpN,
  input  logic                  snoopReqN,
  input  logic                  breakEvt,
  input  logic                  snoopDone,
  output logic                  pbeN,
  output logic [STATE_W-1:0]    stateCode,
  output logic [NUM_STATES-1:0] stateOneHot,
  output logic                  coreClkEn,
  output logic                  busClkEn
);
  pinAct_t     pinAct;
  ctrlStrobe_t strobe;
  pkgState_e   state;
  logic        stopAct;

  pkgpwr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .pinRawN({stpClkN, slpN, dpSlpN, snoopReqN}),
    .strobe(strobe), .pinAct(pinAct), .pbeN(pbeN),
    .coreClkEn(coreClkEn), .busClkEn(busClkEn)
  );

  pkgpwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinAct(pinAct), .breakEvt(breakEvt),
    .snoopDone(snoopDone), .strobe(strobe), .state(state)
  );

  assign stateCode = state;
  assign stopAct   = pinAct.stop;

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
    assign stateOneHot[i] = (stateCode == STATE_W'(i));
  end
endmodule

// File: rtl/pkgpwr_chk.sv
module pkgpwr_chk
  import pkgpwr_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [STATE_W-1:0]    stateCode,
  input logic [NUM_STATES-1:0] stateOneHot,
  input logic                  pbeN,
  input logic                  breakEvt,
  input logic                  snoopDone,
  input logic                  stopAct,
  input logic                  coreClkEn,
  input logic                  busClkEn
);
  AST_NORMAL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0 && $past(stateCode) != 3'd0) |-> $past(stateCode) == 3'd1); // R1
  AST_SNOOP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateCode) == 3'd2 && stateCode != 3'd2) |-> (stateCode == 3'd1 && $past(snoopDone))); // R2
  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd4 && $past(stateCode) != 3'd4) |-> $past(stateCode) == 3'd3); // R6
  AST_PBE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (breakEvt && stopAct) |=> !pbeN); // R5
  AST_PBE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pbeN) && !pbeN) |-> $past(breakEvt && stopAct)); // R5
  AST_PBE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(pbeN) && pbeN) |-> !$past(stopAct)); // R7
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOneHot) == 1); // R10
  AST_CORE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn == (stateOneHot[0] | stateOneHot[2])); // R9
  AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    busClkEn == !stateOneHot[4]); // R9
endmodule

bind pkg_power_seq pkgpwr_chk u_chk (
  .clk(clk), .rstN(rstN), .stateCode(stateCode), .stateOneHot(stateOneHot),
  .pbeN(pbeN), .breakEvt(breakEvt), .snoopDone(snoopDone), .stopAct(stopAct),
  .coreClkEn(coreClkEn), .busClkEn(busClkEn)
);

// File: tb/sim_pkg_power_seq.sv
`timescale 1ns/1ps
module sim_pkg_power_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stpClkN = 1'b1, slpN = 1'b1, dpSlpN = 1'b1, snoopReqN = 1'b1;
  logic breakEvt = 1'b0, snoopDone = 1'b0;
  logic pbeN, coreClkEn, busClkEn;
  logic [2:0] stateCode;
  logic [4:0] stateOneHot;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pkg_power_seq u0 (
    .clk(clk), .rstN(rstN), .stpClkN(stpClkN), .slpN(slpN), .dpSlpN(dpSlpN),
    .snoopReqN(snoopReqN), .breakEvt(breakEvt), .snoopDone(snoopDone),
    .pbeN(pbeN), .stateCode(stateCode), .stateOneHot(stateOneHot),
    .coreClkEn(coreClkEn), .busClkEn(busClkEn)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkState(string req, int exp);
    chk({req, " state"}, int'(stateCode), exp);
    chk({req, " onehot"}, int'(stateOneHot), 1 << exp);
    chk({req, " R9 core"}, int'(coreClkEn), (exp == 0 || exp == 2) ? 1 : 0);
    chk({req, " R9 bus"}, int'(busClkEn), (exp != 4) ? 1 : 0);
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPins(bit stp, bit slp, bit dp, bit snp);
    stpClkN = ~stp; slpN = ~slp; dpSlpN = ~dp; snoopReqN = ~snp;
  endtask

  task automatic doReset();
    rstN = 1'b0; setPins(0, 0, 0, 0); breakEvt = 1'b0; snoopDone = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
  endtask

  task automatic goTo(int s);
    doReset();
    if (s >= 1) begin setPins(1, 0, 0, 0); waitN(4); end
    if (s == 2) begin setPins(1, 0, 0, 1); waitN(4); end
    if (s >= 3) begin setPins(1, 1, 0, 0); waitN(4); end
    if (s == 4) begin setPins(1, 1, 1, 0); waitN(4); end
  endtask

  task automatic pulseBreak();
    breakEvt = 1'b1; waitN(1); breakEvt = 1'b0;
  endtask

  // ladder from the requirements: one step per settled cycle, no snoopDone
  function automatic int ladder(int s, bit stp, bit slp, bit dp, bit snp);
    case (s)
      0: return stp ? 1 : 0;
      1: return !stp ? 0 : snp ? 2 : slp ? 3 : 1;
      2: return 2;
      3: return !slp ? 1 : dp ? 4 : 3;
      default: return !dp ? 3 : 4;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    doReset();
    chkState("R11", 0);
    chk("R11 pbeN", int'(pbeN), 1);

    // R12 latency and R1 entry
    @(negedge clk); setPins(1, 0, 0, 0);
    waitN(2); chk("R12 before third edge", int'(stateCode), 0);
    waitN(1); chk("R12 at third edge", int'(stateCode), 1);
    chkState("R1 stop grant", 1);

    // R5 break ignored without stop-clock
    doReset();
    pulseBreak(); waitN(1);
    chk("R5 break ignored", int'(pbeN), 1);
    setPins(1, 0, 0, 0); waitN(4);
    pulseBreak();
    chk("R5 break sets pbe", int'(pbeN), 0);
    pulseBreak(); waitN(1); pulseBreak();
    chk("R7 repeat break pbe", int'(pbeN), 0);
    chk("R7 repeat break state", int'(stateCode), 1);
    // R7 release with breaks arriving at the same time
    setPins(0, 0, 0, 0);
    breakEvt = 1'b1;
    waitN(2); chk("R7 pbe held", int'(pbeN), 0);
    waitN(1); chk("R7 pbe released", int'(pbeN), 1);
    chk("R1 back to normal", int'(stateCode), 0);
    waitN(1); breakEvt = 1'b0;
    chk("R7 stays released", int'(pbeN), 1);

    // R2 snoop outranks sleep when both arrive together
    goTo(1);
    setPins(1, 1, 0, 1); waitN(3);
    chkState("R2 snoop priority", 2);
    // R8 pins ignored in snoop
    setPins(0, 0, 1, 1); waitN(5);
    chk("R8 snoop holds", int'(stateCode), 2);
    setPins(1, 1, 0, 0); waitN(4);
    chk("R8 snoop holds after release", int'(stateCode), 2);
    snoopDone = 1'b1; waitN(1); snoopDone = 1'b0;
    chk("R2 snoop done", int'(stateCode), 1);
    waitN(1);
    chk("R3 sleep after snoop", int'(stateCode), 3);

    // sweep: every start state, every pin combination
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 16; c++) begin
        int exp;
        goTo(s);
        chk("R6 start reached", int'(stateCode), s);
        setPins(c[3], c[2], c[1], c[0]);
        exp = s;
        for (int k = 0; k < 8; k++) exp = ladder(exp, c[3], c[2], c[1], c[0]);
        waitN(10);
        chkState($sformatf("R3 R4 R6 R8 sweep s=%0d c=%0d", s, c), exp);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule